// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between an on-chip request port and an external asynchronous static RAM of 512K sixteen-bit words. A single request carries a read/write flag, a 19-bit word address, 16 bits of write data and two byte-enable bits. The controller turns each request into a sequence on the RAM's active-low strobes: chip enable, output enable, write enable, and one select per byte lane. It also drives the address and the outgoing data bus together with that bus's tristate enable.

The RAM has no clock, so the controller holds each access for a fixed number of clock cycles, `WAIT_CYCLES`, chosen to cover the access time of the speed grade in use. A write adds a setup cycle before the write strobe and a hold cycle after it, and the data drivers stay on during both. A read samples the data bus in the last strobe cycle and returns it with a one-cycle `resp_valid` pulse. Bytes on lanes that were not selected come back as zero. Every access is followed by at least one cycle with all strobes inactive.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it falls, `mem_ce_n`, `mem_oe_n`, `mem_we_n`, `mem_lb_n` and `mem_ub_n` are 1, `mem_dq_oe` is 0, `resp_valid` is 0 and `req_ready` is 1.
- R2: Whenever `mem_ce_n` is 1, all other strobes are 1 and `mem_dq_oe` is 0. `req_ready` is 1 only when no access is in progress.
- R3: For a read with at least one byte enabled, `mem_ce_n` and `mem_oe_n` are 0 for exactly `WAIT_CYCLES` cycles, starting the cycle after acceptance. During that time `mem_we_n` is 1 and `mem_dq_oe` is 0.
- R4: For a write with at least one byte enabled, `mem_dq_oe` rises one cycle before `mem_we_n` falls. `mem_we_n` then stays 0 for exactly `WAIT_CYCLES` cycles, and `mem_dq_oe` stays 1 for one more cycle after `mem_we_n` rises. In total `mem_ce_n` is 0 for `WAIT_CYCLES`+2 cycles, `mem_oe_n` stays 1 throughout, and `mem_dq_out` carries the request's write data.
- R5: `req_be[0]` selects the lower lane (bits 7:0): `mem_lb_n` is 0 while the access is active. `req_be[1]` selects the upper lane (bits 15:8) in the same way through `mem_ub_n`. A lane whose enable bit is 0 keeps its select at 1, so a write leaves that byte in the RAM unchanged.
- R6: A read returns `mem_dq_in` as sampled in its last strobe cycle, with the bytes of deselected lanes forced to zero. `resp_valid` is 1 for exactly one cycle, the cycle after the last strobe cycle.
- R7: A request with `req_be` = 2'b00 is accepted and causes no strobe activity, and `req_ready` stays 1. For such a read, `resp_valid` is 1 in the next cycle with `resp_rdata` = 0. Such a write changes no RAM content.
- R8: While `mem_ce_n` is 0, `mem_addr`, `mem_lb_n` and `mem_ub_n` do not change.
- R9: After `mem_ce_n` rises, it stays 1, with every strobe inactive, for at least one cycle before the next access.
- R10: `mem_oe_n` and `mem_we_n` are never 0 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables: bit 0 lower lane, bit 1 upper lane |
| resp_valid | output | 1 | Read data valid, one-cycle pulse |
| resp_rdata | output | 16 | Read data, deselected bytes zero |
| mem_addr | output | 19 | RAM address |
| mem_ce_n | output | 1 | RAM chip enable, active low |
| mem_oe_n | output | 1 | RAM output enable, active low |
| mem_we_n | output | 1 | RAM write enable, active low |
| mem_lb_n | output | 1 | Lower byte select, active low |
| mem_ub_n | output | 1 | Upper byte select, active low |
| mem_dq_out | output | 16 | Data to drive onto the RAM bus |
| mem_dq_oe | output | 1 | Enable for the bus tristate drivers |
| mem_dq_in | input | 16 | Data read from the RAM bus |

## Verification
Reads and writes are tried with each of the three non-empty byte-enable patterns, so that a swapped or merged lane select shows up both in which byte a write changes and in which byte a read zeroes. The RAM model drives a fixed, distinctive value on deselected lanes, which separates proper masking from a plain pass-through. Writing a known word and then partially overwriting it checks that the untouched byte survives. Requests with both enables cleared, for reads and for writes, separate the immediate-completion path from the normal strobe sequence. Counting the strobe cycles per access pins down the wait-state, setup, hold and gap timing.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_SETUP  = 3'd1,
      ST_ACCESS = 3'd2,
      ST_HOLD   = 3'd3,
      ST_GAP    = 3'd4
   } ctl_state_t;

endpackage

// File: rtl/sram_wait_timer.sv
// Down-counter that stretches an access across WAIT_CYCLES clock cycles.
module sram_wait_timer #(
   parameter int WAIT_CYCLES = 3
) (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic run,
   output logic last
);
   localparam int CNT_W = (WAIT_CYCLES > 1) ? $clog2(WAIT_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(WAIT_CYCLES - 1);

   if (WAIT_CYCLES < 1) begin : g_bad_wait
      $error("sram_wait_timer: WAIT_CYCLES must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= LOAD_VAL;
      end else if (run && (cnt_q != '0)) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last = (cnt_q == '0);

   // R3
   timer_range_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= LOAD_VAL);

endmodule

// File: rtl/sram_lane_mask.sv
// Per-lane select strobes and read-data zeroing for deselected lanes.
module sram_lane_mask #(
   parameter int DATA_W = 16,
   parameter int LANE_W = 8
) (
   input  logic                       active,
   input  logic [DATA_W/LANE_W-1:0]   lane_en,
   input  logic [DATA_W-1:0]          raw_rdata,
   output logic [DATA_W/LANE_W-1:0]   lane_sel_n,
   output logic [DATA_W-1:0]          masked_rdata
);
   localparam int LANES = DATA_W / LANE_W;

   if ((DATA_W % LANE_W) != 0) begin : g_bad_lane
      $error("sram_lane_mask: DATA_W must be a multiple of LANE_W");
   end

   for (genvar li = 0; li < LANES; li++) begin : g_lane
      assign lane_sel_n[li] = ~(active & lane_en[li]);
      assign masked_rdata[li*LANE_W +: LANE_W] =
         lane_en[li] ? raw_rdata[li*LANE_W +: LANE_W] : '0;
   end

endmodule

// File: rtl/sram_lane_ctrl.sv
// Controller for an external asynchronous SRAM with two byte lanes.
module sram_lane_ctrl
   import sram_lane_pkg::*;
#(
   parameter int ADDR_W      = 19,
   parameter int DATA_W      = 16,
   parameter int WAIT_CYCLES = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [1:0]        req_be,
   output logic              resp_valid,
   output logic [DATA_W-1:0] resp_rdata,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_ce_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic              mem_lb_n,
   output logic              mem_ub_n,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);
   localparam int LANE_W = DATA_W / 2;

   if ((DATA_W % 2) != 0 || LANE_W < 1) begin : g_bad_data
      $error("sram_lane_ctrl: DATA_W must split into two equal lanes");
   end
   if (ADDR_W < 1) begin : g_bad_addr
      $error("sram_lane_ctrl: ADDR_W must be positive");
   end

   ctl_state_t        state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [1:0]        be_q;
   logic              wr_q;
   logic              resp_valid_q;
   logic [DATA_W-1:0] rdata_q;

   logic              accept;
   logic              be_any;
   logic              timer_load;
   logic              timer_last;
   logic              ce_active;
   logic              in_access;
   logic [1:0]        lane_sel_n;
   logic [DATA_W-1:0] masked_rdata;

   assign accept    = req_valid && (state_q == ST_IDLE);
   assign be_any    = |req_be;
   assign in_access = (state_q == ST_ACCESS);
   assign ce_active = (state_q == ST_SETUP) || in_access || (state_q == ST_HOLD);

   // Reads load the timer at acceptance; writes load it in the setup cycle.
   assign timer_load = (accept && be_any && !req_write) || (state_q == ST_SETUP);

   sram_wait_timer #(
      .WAIT_CYCLES (WAIT_CYCLES)
   ) wait_i (
      .clk  (clk),
      .rst  (rst),
      .load (timer_load),
      .run  (in_access),
      .last (timer_last)
   );

   sram_lane_mask #(
      .DATA_W (DATA_W),
      .LANE_W (LANE_W)
   ) lane_i (
      .active       (ce_active),
      .lane_en      (be_q),
      .raw_rdata    (mem_dq_in),
      .lane_sel_n   (lane_sel_n),
      .masked_rdata (masked_rdata)
   );

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE: begin
            if (accept && be_any) begin
               state_d = req_write ? ST_SETUP : ST_ACCESS;
            end
         end
         ST_SETUP:  state_d = ST_ACCESS;
         ST_ACCESS: if (timer_last) state_d = wr_q ? ST_HOLD : ST_GAP;
         ST_HOLD:   state_d = ST_GAP;
         ST_GAP:    state_d = ST_IDLE;
         default:   state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q      <= ST_IDLE;
         addr_q       <= '0;
         wdata_q      <= '0;
         be_q         <= '0;
         wr_q         <= 1'b0;
         resp_valid_q <= 1'b0;
         rdata_q      <= '0;
      end else begin
         state_q      <= state_d;
         resp_valid_q <= 1'b0;
         if (accept && be_any) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            be_q    <= req_be;
            wr_q    <= req_write;
         end
         if (accept && !be_any && !req_write) begin
            resp_valid_q <= 1'b1;
            rdata_q      <= '0;
         end else if (in_access && timer_last && !wr_q) begin
            resp_valid_q <= 1'b1;
            rdata_q      <= masked_rdata;
         end
      end
   end

   assign req_ready  = (state_q == ST_IDLE);
   assign resp_valid = resp_valid_q;
   assign resp_rdata = rdata_q;
   assign mem_addr   = addr_q;
   assign mem_ce_n   = ~ce_active;
   assign mem_we_n   = ~(in_access && wr_q);
   assign mem_oe_n   = ~(in_access && !wr_q);
   assign mem_lb_n   = lane_sel_n[0];
   assign mem_ub_n   = lane_sel_n[1];
   assign mem_dq_out = wdata_q;
   assign mem_dq_oe  = ce_active && wr_q;

   // Arms the history-based checks one cycle after reset ends.
   logic armed_q;
   always_ff @(posedge clk) begin
      if (rst) armed_q <= 1'b0;
      else     armed_q <= 1'b1;
   end

   // R1
   reset_idle_chk: assert property (@(posedge clk)
      rst |=> (mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n
               && !mem_dq_oe && !resp_valid && req_ready));

   // R2
   deselect_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      mem_ce_n |-> (mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n && !mem_dq_oe));

   // R3
   read_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
      !mem_oe_n |-> (!mem_dq_oe && !mem_ce_n));

   // R4
   write_drive_chk: assert property (@(posedge clk) disable iff (rst)
      !mem_we_n |-> mem_dq_oe);

   // R4
   drive_lead_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
      $fell(mem_we_n) |-> $past(mem_dq_oe));

   // R4
   drive_trail_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
      $rose(mem_we_n) |-> mem_dq_oe ##1 !mem_dq_oe);

   // R5
   lane_pick_chk: assert property (@(posedge clk) disable iff (rst)
      !mem_ce_n |-> !(mem_lb_n && mem_ub_n));

   // R6
   resp_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      resp_valid |=> !resp_valid);

   // R8
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
      (!mem_ce_n && $past(!mem_ce_n)) |->
         ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));

   // R9
   idle_gap_chk: assert property (@(posedge clk) disable iff (rst || !armed_q)
      $rose(mem_ce_n) |=> mem_ce_n);

   // R10
   strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
      !(!mem_oe_n && !mem_we_n));

endmodule

// File: tb/sram_lane_ctrl_tb.sv
module sram_lane_ctrl_tb_top;
   localparam int WAIT = 3;

   logic        clk = 1'b0;
   logic        rst;
   logic        req_valid;
   logic        req_ready;
   logic        req_write;
   logic [18:0] req_addr;
   logic [15:0] req_wdata;
   logic [1:0]  req_be;
   logic        resp_valid;
   logic [15:0] resp_rdata;
   logic [18:0] mem_addr;
   logic        mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n;
   logic [15:0] mem_dq_out;
   logic        mem_dq_oe;
   logic [15:0] mem_dq_in;

   int checks = 0;
   int errors = 0;

   logic [15:0] ram_model [16];
   logic [15:0] shadow    [16];

   always #5 clk = ~clk;

   sram_lane_ctrl #(.WAIT_CYCLES(WAIT)) dut_i (
      .clk(clk), .rst(rst),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
      .resp_valid(resp_valid), .resp_rdata(resp_rdata),
      .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
      .mem_we_n(mem_we_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
      .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
   );

   // RAM model: deselected lanes carry a recognisable junk byte.
   always_comb begin
      mem_dq_in = 16'hDEAD;
      if (!mem_ce_n && !mem_oe_n && mem_we_n) begin
         mem_dq_in[7:0]  = mem_lb_n ? 8'h5A : ram_model[mem_addr[3:0]][7:0];
         mem_dq_in[15:8] = mem_ub_n ? 8'hA5 : ram_model[mem_addr[3:0]][15:8];
      end
   end

   always @(posedge clk) begin
      if (!mem_ce_n && !mem_we_n && mem_dq_oe) begin
         if (!mem_lb_n) ram_model[mem_addr[3:0]][7:0]  = mem_dq_out[7:0];
         if (!mem_ub_n) ram_model[mem_addr[3:0]][15:8] = mem_dq_out[15:8];
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Issues one request and records what the strobes do until ready returns.
   task automatic issue(input bit wr, input logic [18:0] a, input logic [15:0] d,
                        input logic [1:0] be,
                        output int ce_lo, output int we_lo, output int oe_lo,
                        output int drv, output int resp_n, output int quiet,
                        output logic [15:0] got, output bit addr_bad);
      ce_lo = 0; we_lo = 0; oe_lo = 0; drv = 0; resp_n = 0; quiet = 0;
      got = 16'h0; addr_bad = 1'b0;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
      @(negedge clk);
      req_valid = 1'b0;
      for (int i = 0; i < 40; i++) begin
         if (req_ready) break;
         if (!mem_ce_n) begin
            ce_lo++;
            if (mem_addr != a || mem_lb_n != !be[0] || mem_ub_n != !be[1]) addr_bad = 1'b1;
         end
         if (!mem_we_n) we_lo++;
         if (!mem_oe_n) oe_lo++;
         if (mem_dq_oe) drv++;
         if (resp_valid) begin resp_n++; got = resp_rdata; end
         if (mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n) quiet++;
         @(negedge clk);
      end
   endtask

   task automatic t_reset();
      rst = 1'b1; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_wdata = '0; req_be = '0;
      repeat (3) @(negedge clk);
      // R1
      chk(mem_ce_n && mem_oe_n && mem_we_n && mem_lb_n && mem_ub_n, "R1 strobes",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_lb_n, mem_ub_n}, 5'h1f);
      chk(!mem_dq_oe && !resp_valid && req_ready, "R1 bus/ready",
          {mem_dq_oe, resp_valid, req_ready}, 3'b001);
      rst = 1'b0;
      @(negedge clk);
      chk(mem_ce_n && req_ready && !mem_dq_oe, "R1 after release",
          {mem_ce_n, req_ready, mem_dq_oe}, 3'b110);
   endtask

   task automatic t_write(input logic [18:0] a, input logic [15:0] d, input logic [1:0] be);
      int ce_lo, we_lo, oe_lo, drv, resp_n, quiet;
      logic [15:0] got; bit addr_bad;
      issue(1'b1, a, d, be, ce_lo, we_lo, oe_lo, drv, resp_n, quiet, got, addr_bad);
      if (be[0]) shadow[a[3:0]][7:0]  = d[7:0];
      if (be[1]) shadow[a[3:0]][15:8] = d[15:8];
      // R4
      chk(we_lo == WAIT, "R4 we cycles", we_lo, WAIT);
      chk(ce_lo == WAIT + 2 && drv == WAIT + 2, "R4 ce/drive cycles", {ce_lo[7:0], drv[7:0]},
          {8'(WAIT + 2), 8'(WAIT + 2)});
      // R10
      chk(oe_lo == 0, "R10 oe during write", oe_lo, 0);
      // R8
      chk(!addr_bad, "R8 addr/lanes stable", addr_bad, 0);
      // R9
      chk(quiet >= 1, "R9 idle gap", quiet, 1);
   endtask

   task automatic t_read(input logic [18:0] a, input logic [1:0] be);
      int ce_lo, we_lo, oe_lo, drv, resp_n, quiet;
      logic [15:0] got, exp; bit addr_bad;
      issue(1'b0, a, 16'h0, be, ce_lo, we_lo, oe_lo, drv, resp_n, quiet, got, addr_bad);
      exp = {be[1] ? shadow[a[3:0]][15:8] : 8'h00, be[0] ? shadow[a[3:0]][7:0] : 8'h00};
      // R3
      chk(oe_lo == WAIT && ce_lo == WAIT, "R3 read strobe cycles", {oe_lo[7:0], ce_lo[7:0]},
          {8'(WAIT), 8'(WAIT)});
      chk(we_lo == 0 && drv == 0, "R3 no write/drive", {we_lo[7:0], drv[7:0]}, 0);
      // R6 / R5
      chk(resp_n == 1, "R6 single response", resp_n, 1);
      chk(got == exp, "R6 R5 read data lanes", got, exp);
      // R8
      chk(!addr_bad, "R8 addr/lanes stable", addr_bad, 0);
      // R9
      chk(quiet >= 1, "R9 idle gap", quiet, 1);
   endtask

   task automatic t_empty(input bit wr, input logic [18:0] a);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = 16'hFFFF; req_be = 2'b00;
      @(negedge clk);
      req_valid = 1'b0;
      // R7
      chk(mem_ce_n && mem_we_n && mem_oe_n, "R7 no strobes",
          {mem_ce_n, mem_we_n, mem_oe_n}, 3'b111);
      chk(req_ready, "R7 ready kept", req_ready, 1);
      if (!wr) chk(resp_valid && resp_rdata == 16'h0, "R7 empty read resp",
                   {resp_valid, resp_rdata}, 17'h10000);
      else     chk(!resp_valid, "R7 empty write no resp", resp_valid, 0);
      @(negedge clk);
      chk(!resp_valid && mem_ce_n, "R7 quiet after", {resp_valid, mem_ce_n}, 2'b01);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 16; i++) begin
         ram_model[i] = 16'h1000 + 16'(i);
         shadow[i]    = 16'h1000 + 16'(i);
      end
      t_reset();
      // R4 R5: full word, then each lane alone
      t_write(19'h00003, 16'hBEEF, 2'b11);
      t_read (19'h00003, 2'b11);
      t_write(19'h00003, 16'h1234, 2'b01);
      t_read (19'h00003, 2'b11);
      t_write(19'h00003, 16'h5678, 2'b10);
      t_read (19'h00003, 2'b11);
      // R6: partial reads zero the other lane
      t_read (19'h00003, 2'b01);
      t_read (19'h00003, 2'b10);
      t_write(19'h7FFF5, 16'hCAFE, 2'b11);
      t_read (19'h7FFF5, 2'b10);
      // R7: empty requests
      t_empty(1'b0, 19'h00003);
      t_empty(1'b1, 19'h00003);
      t_read (19'h00003, 2'b11);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule